// File: doc/BRIEF.md
# MSI Snooping Cache Coherence Controller

This block keeps the coherence state of a small direct-mapped set of cache lines on a shared snooping bus with an invalidation protocol. Each line is Invalid, Shared or Modified and carries a tag. The processor side presents read and write requests. The controller either answers them at once as hits or stalls them while it asks the bus for a shared fill, for an exclusive fill, or for a writeback of a dirty line that must be replaced.

On the bus side the controller watches transactions issued by other caches. A remote shared read of a line held Modified makes it supply the dirty data, through a flush strobe, and keep a shared copy. A remote exclusive read forces the local copy to Invalid, and a Modified line is flushed first. The data array, arbitration among bus masters and any ordering model above the bus are outside the block. A single grant input tells the controller that the bus is its own in the current cycle.

An address is `{tag, index}`, with the index in the low `IDX_W` bits. Bus commands are encoded 0 idle, 1 shared read, 2 exclusive read, 3 writeback.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: A read of a line that is Invalid, or whose tag does not match while the line is not Modified, raises `bus_req` with command 1 and `bus_addr` equal to the request address. After the grant the line is Shared with the new tag.
- R2: A write to a line that is Invalid or not present raises `bus_req` with command 2 for the request address. After the grant the line is Modified.
- R3: A write to a present Shared line raises `bus_req` with command 2. After the grant the line is Modified.
- R4: A read of a present Shared or Modified line, or a write of a present Modified line, asserts `cpu_hit` in the same cycle with `bus_req` low.
- R5: A snooped command 1 that matches a Modified line asserts `snp_flush` in that cycle, and the line becomes Shared.
- R6: A snooped command 2 that matches a Modified line asserts `snp_flush` in that cycle, and the line becomes Invalid.
- R7: A snooped command 2 that matches a Shared line invalidates it without `snp_flush`. A snooped command 1 that matches a Shared line leaves it Shared without `snp_flush`.
- R8: No write completes on a line that is not Modified. Such a write stalls and first obtains the line with command 2.
- R9: A request that needs the bus keeps `cpu_stall` high and `bus_req` asserted until `bus_grant`. The state changes at the clock edge that ends the grant cycle, and the access hits in the following cycle.
- R10: Snoops of a line that is Invalid, or whose stored tag differs from the snooped tag, cause no flush and no state change.
- R11: A request whose tag differs from that of a Modified line in the same index first issues command 3 with `bus_addr` set to the old line's address. After that grant the line is Invalid and the fill of R1 or R2 follows.
- R12: After reset every line is Invalid, `bus_req` is low and `snp_flush` is low.
- R13: When a valid snoop matches the line that the processor is addressing in the same cycle, the processor access neither hits nor requests the bus in that cycle.
- R14: A snoop presented in a cycle where `bus_grant` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid, held until it hits |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | IDX_W+TAG_W | Request address {tag, index} |
| cpu_hit | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Request pending, not completed this cycle |
| bus_req | output | 1 | Controller wants the bus |
| bus_cmd | output | 2 | 0 idle, 1 shared read, 2 exclusive read, 3 writeback |
| bus_addr | output | IDX_W+TAG_W | Address of the requested transaction |
| bus_grant | input | 1 | Bus owned by this controller this cycle |
| snp_valid | input | 1 | Remote transaction visible on the bus |
| snp_cmd | input | 2 | Remote command, same encoding as bus_cmd |
| snp_addr | input | IDX_W+TAG_W | Remote transaction address |
| snp_flush | output | 1 | Supply dirty data for the snooped line this cycle |

## Verification
A wrong line state does not show up at once. It appears at the next access to that index, as a hit where a bus command should appear, as a command of the wrong kind, or as a flush that is missing or extra on the next snoop. The bench therefore follows every state-changing event (fill, writeback, snoop) with a probe access or snoop to the same line in the next few cycles. A probe to a line with the same index but a different tag shows whether the tag is kept correctly, and a snoop during a grant checks that bus ownership blocks updates from outside.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_IDLE = 2'd0,
        BC_RD   = 2'd1,
        BC_RDX  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;
endpackage

// File: rtl/msi_req_plan.sv
module msi_req_plan
    import msi_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             req,
    input  logic             we,
    input  line_st_e         st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit,
    output logic             need_bus,
    output bus_cmd_e         cmd,
    output logic             use_victim
);
    logic present;

    always_comb begin
        present    = (line_tag == req_tag) && (st != LN_INV);
        hit        = 1'b0;
        need_bus   = 1'b0;
        cmd        = BC_IDLE;
        use_victim = 1'b0;
        if (req) begin
            if (present) begin
                if (!we || st == LN_MOD) begin
                    hit = 1'b1;
                end else begin
                    need_bus = 1'b1;
                    cmd      = BC_RDX;
                end
            end else if (st == LN_MOD) begin
                need_bus   = 1'b1;
                cmd        = BC_WB;
                use_victim = 1'b1;
            end else begin
                need_bus = 1'b1;
                cmd      = we ? BC_RDX : BC_RD;
            end
        end
    end
endmodule

// File: rtl/msi_snoop_eval.sv
module msi_snoop_eval
    import msi_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             valid,
    input  logic             owned,
    input  bus_cmd_e         cmd,
    input  line_st_e         st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             match,
    output logic             flush,
    output line_st_e         next_st
);
    always_comb begin
        match   = valid && !owned && (cmd == BC_RD || cmd == BC_RDX)
                  && (st != LN_INV) && (line_tag == snp_tag);
        flush   = match && (st == LN_MOD);
        next_st = st;
        if (match) begin
            next_st = (cmd == BC_RD) ? LN_SHR : LN_INV;
        end
    end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4,
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_grant,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush
);
    localparam int NLINES = 1 << IDX_W;

    typedef struct packed {
        line_st_e [NLINES-1:0]            st;
        logic     [NLINES-1:0][TAG_W-1:0] tag;
    } dir_t;

    dir_t dir_q, dir_d;

    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag;
    logic             plan_hit, plan_need, plan_victim;
    bus_cmd_e         plan_cmd;
    logic             snp_match, conflict, xfer_done;
    line_st_e         snp_next;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    msi_req_plan #(.TAG_W(TAG_W)) plan_i (
        .req        (cpu_req),
        .we         (cpu_we),
        .st         (dir_q.st[cpu_idx]),
        .line_tag   (dir_q.tag[cpu_idx]),
        .req_tag    (cpu_tag),
        .hit        (plan_hit),
        .need_bus   (plan_need),
        .cmd        (plan_cmd),
        .use_victim (plan_victim)
    );

    msi_snoop_eval #(.TAG_W(TAG_W)) snoop_i (
        .valid    (snp_valid),
        .owned    (bus_grant),
        .cmd      (bus_cmd_e'(snp_cmd)),
        .st       (dir_q.st[snp_idx]),
        .line_tag (dir_q.tag[snp_idx]),
        .snp_tag  (snp_tag),
        .match    (snp_match),
        .flush    (snp_flush),
        .next_st  (snp_next)
    );

    // A same-line snoop takes the line this cycle; the processor waits.
    assign conflict  = snp_match && (snp_idx == cpu_idx);
    assign cpu_hit   = plan_hit && !conflict;
    assign cpu_stall = cpu_req && !cpu_hit;
    assign bus_req   = plan_need && !conflict;
    assign bus_cmd   = plan_cmd;
    assign bus_addr  = plan_victim ? {dir_q.tag[cpu_idx], cpu_idx} : cpu_addr;
    assign xfer_done = bus_req && bus_grant;

    always_comb begin
        dir_d = dir_q;
        if (snp_match) begin
            dir_d.st[snp_idx] = snp_next;
        end
        if (xfer_done) begin
            unique case (plan_cmd)
                BC_WB:  dir_d.st[cpu_idx] = LN_INV;
                BC_RD: begin
                    dir_d.st[cpu_idx]  = LN_SHR;
                    dir_d.tag[cpu_idx] = cpu_tag;
                end
                BC_RDX: begin
                    dir_d.st[cpu_idx]  = LN_MOD;
                    dir_d.tag[cpu_idx] = cpu_tag;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_d;
    end

    // R4: a hit never drives the bus
    p_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> !bus_req);
    // R1: granted shared read leaves the line Shared with the request tag
    p_fill_shared_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && bus_cmd == BC_RD) |=>
        (dir_q.st[$past(cpu_idx)] == LN_SHR && dir_q.tag[$past(cpu_idx)] == $past(cpu_tag)));
    // R8: granted exclusive read gives ownership before any write completes
    p_fill_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && bus_cmd == BC_RDX) |=> dir_q.st[$past(cpu_idx)] == LN_MOD);
    // R11: writeback empties the index
    p_writeback_inv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && bus_cmd == BC_WB) |=> dir_q.st[$past(cpu_idx)] == LN_INV);
    // R5: flush on remote shared read keeps a Shared copy
    p_flush_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_flush && snp_cmd == BC_RD) |=> dir_q.st[$past(snp_idx)] == LN_SHR);
    // R6: flush on remote exclusive read drops the line
    p_flush_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_flush && snp_cmd == BC_RDX) |=> dir_q.st[$past(snp_idx)] == LN_INV);
    // R14: no flush while this controller owns the bus
    p_grant_no_snoop_r14: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> !snp_flush);
endmodule

// File: tb/msi_snoop_ctrl_tb_top.sv
module msi_snoop_ctrl_tb_top;
    localparam int IDX_W = 2;
    localparam int TAG_W = 4;
    localparam int AW    = IDX_W + TAG_W;
    localparam int NVEC  = 9;

    // row: {we, addr, expected kind (0 hit,1 rd,2 rdx,3 wb), expected bus_addr}
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b0, 6'h01, 2'd1, 6'h01},   // R1 read miss
        {1'b0, 6'h01, 2'd0, 6'h00},   // R4 read hit S
        {1'b1, 6'h01, 2'd2, 6'h01},   // R3 write to S
        {1'b1, 6'h01, 2'd0, 6'h00},   // R4 write hit M
        {1'b0, 6'h01, 2'd0, 6'h00},   // R4 read hit M
        {1'b1, 6'h02, 2'd2, 6'h02},   // R2 write miss
        {1'b0, 6'h12, 2'd3, 6'h02},   // R11 evict dirty line
        {1'b0, 6'h02, 2'd1, 6'h02},   // R1 tag mismatch on S line
        {1'b1, 6'h03, 2'd2, 6'h03}    // R2 write miss
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_hit, cpu_stall, bus_req, snp_flush;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic          bus_grant = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    msi_snoop_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut_i (
        .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_hit, .cpu_stall,
        .bus_req, .bus_cmd, .bus_addr, .bus_grant,
        .snp_valid, .snp_cmd, .snp_addr, .snp_flush
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic int kind_now();
        if (cpu_hit) return 0;
        if (bus_req) return int'(bus_cmd);
        return 7;
    endfunction

    task automatic start(input logic we, input logic [AW-1:0] addr);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr;
        #1;
    endtask

    // R9: grant whatever is requested until the access hits
    task automatic finish_access(input string req);
        for (int g = 0; g < 8 && !cpu_hit; g++) begin
            if (bus_req) bus_grant = 1'b1;
            @(posedge clk);
            @(negedge clk);
            bus_grant = 1'b0;
            #1;
        end
        chk(req, int'(cpu_hit), 1);
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic probe(input logic we, input logic [AW-1:0] addr, input int kind, input string req);
        start(we, addr);
        chk(req, kind_now(), kind);
        finish_access(req);
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] addr, input int fl, input string req);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr;
        #1;
        chk(req, int'(snp_flush), fl);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12: idle after reset
        chk("R12 bus_req", int'(bus_req), 0);
        chk("R12 snp_flush", int'(snp_flush), 0);
        start(1'b0, 6'h15);
        chk("R12 line invalid", kind_now(), 1);
        chk("R9 stall", int'(cpu_stall), 1);
        repeat (2) @(negedge clk);
        #1;
        chk("R9 held without grant", kind_now(), 1);
        cpu_req = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [14:0] v;
            v = VEC[i];
            start(v[14], v[13:8]);
            chk($sformatf("R1/R2/R3/R4/R11 row %0d kind", i), kind_now(), int'(v[7:6]));
            if (v[7:6] != 2'd0) begin
                chk($sformatf("R9 row %0d stall", i), int'(cpu_stall), 1);
                chk($sformatf("R1/R11 row %0d addr", i), int'(bus_addr), int'(v[5:0]));
            end
            finish_access($sformatf("R9 row %0d completes", i));
        end
        // state: idx0 I, idx1 M t0, idx2 S t0, idx3 M t0

        snoop(2'd1, 6'h01, 1, "R5 flush");
        probe(1'b0, 6'h01, 0, "R5 kept shared");
        probe(1'b1, 6'h01, 2, "R8 write to S needs ownership");

        snoop(2'd2, 6'h03, 1, "R6 flush");
        probe(1'b0, 6'h03, 1, "R6 invalidated");

        snoop(2'd2, 6'h02, 0, "R7 no flush on S");
        probe(1'b0, 6'h02, 1, "R7 invalidated");
        snoop(2'd1, 6'h02, 0, "R7 shared read no flush");
        probe(1'b0, 6'h02, 0, "R7 still shared");

        snoop(2'd2, 6'h11, 0, "R10 tag mismatch");
        probe(1'b1, 6'h01, 0, "R10 line untouched");
        snoop(2'd2, 6'h00, 0, "R10 invalid line");

        // R13: same-line snoop and read in one cycle
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 6'h01;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 6'h01;
        #1;
        chk("R13 no hit", int'(cpu_hit), 0);
        chk("R13 no bus", int'(bus_req), 0);
        chk("R13 flush", int'(snp_flush), 1);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk("R13 hit after", int'(cpu_hit), 1);
        @(negedge clk);
        cpu_req = 1'b0;

        // R14: snoop during own grant is ignored (idx1 is Shared)
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 6'h00;
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 6'h01;
        bus_grant = 1'b1;
        #1;
        chk("R14 own request", kind_now(), 2);
        @(negedge clk);
        bus_grant = 1'b0; snp_valid = 1'b0;
        #1;
        chk("R9 hit after grant", int'(cpu_hit), 1);
        @(negedge clk);
        cpu_req = 1'b0;
        probe(1'b0, 6'h01, 0, "R14 line kept");

        report();
    end
endmodule